// File: doc/BRIEF.md
# Two-Stage ECG Sample Compressor

This block shrinks a slow stream of 11-bit electrocardiogram samples in two steps. First, an error-feedback requantizer removes the K least significant bits of each sample. It adds the removed fraction to a running accumulator. Whenever that accumulator reaches the weight of one coarse step, the coarse value for that sample is raised by one. The coarse stream therefore toggles between neighbouring levels with a duty cycle that tracks the lost fraction, much like a pulse-width-modulated signal.

Second, each coarse symbol is mapped through a constant prefix-code table. Values near mid-scale, where a baseline-centred trace spends most of its time, get the shortest codewords. The codewords are then packed, most significant bit first and with no gaps, into 32-bit output words. A flush request pushes out the last partial word, padded with zeros, together with its count of valid bits.

The code table is an order-g exponential-Golomb code over a zig-zag rank around mid-scale. It is computed at elaboration, with g chosen so that no codeword exceeds 16 bits. The packer is a three-state machine:

- **FILL**: accepts one sample per clock while it holds fewer than 32 bits.
- **SPILL**: entered when an append reaches 32 bits or more; emits the top word and returns to FILL.
- **TAIL**: entered when a flush arrives with bits pending; emits the padded partial word and returns to FILL.

Transitions FILL→SPILL (word full) and FILL→TAIL (flush with data) are the only branches. Both SPILL and TAIL return to FILL after one cycle.

Top module: `ecg_compressor`

## Requirements
- R1: After synchronous active-high reset, `in_ready` is 1 (with `flush` low), `out_valid` is 0, `out_nbits` is 0, the accumulator is zero and the packer holds no bits.
- R2: For each accepted sample, coarse = sample >> K and the low K bits are added to the accumulator. If the sum reaches 2^K, the emitted symbol is coarse+1 and 2^K is removed from the accumulator. Otherwise the symbol is coarse and the sum is kept.
- R3: When coarse is already the largest value (all ones) and a pulse occurs, the symbol stays at the largest value and the accumulator still drops by 2^K.
- R4: Symbol s of C = 11−K bits is coded as follows: rank r = 2(s−m) if s ≥ m, else 2(m−s)−1, with m = 2^(C−1); order g = C−5 if C > 6, else 0; v = r + 2^g. The codeword is v written in 2·⌊log2 v⌋ − g + 1 bits. With K = 5, symbol 32 is the single bit 1 and symbol 33 is 011.
- R5: Codeword bits are appended MSB first. When 32 or more bits are held, the oldest 32 appear on `out_word` (first bit at bit 31) with `out_nbits` = 32 and `out_valid` high for exactly one cycle.
- R6: A codeword that crosses a word boundary is split with no gap: its leading bits end one word and its remaining bits start the next.
- R7: A flush with n > 0 bits held emits one word with those bits at the top, zeros below, and `out_nbits` = n. A flush with nothing held emits nothing.
- R8: `in_ready` is low while a word is being emitted and in any cycle where `flush` is high. A sample presented then is not taken and is held by the source.
- R9: The accumulator changes only on cycles where a sample is taken.
- R10: Flush empties the packer but leaves the accumulator unchanged, so the pulse pattern continues across flushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present |
| in_sample | input | 11 | Unsigned sample value |
| flush | input | 1 | Emit the pending partial word |
| in_ready | output | 1 | Sample is taken on this clock when in_valid is high |
| out_valid | output | 1 | One-cycle strobe for out_word |
| out_word | output | 32 | Packed code bits, first bit at MSB |
| out_nbits | output | 6 | Number of valid bits in out_word |

## Verification
The hardest conditions to reach are a saturating pulse and a codeword that straddles two output words. A saturating pulse needs the coarse value at its ceiling and the accumulator at threshold in the same cycle. The bench reaches it by repeating the full-scale sample, whose fraction is nearly a whole step, so pulses fire on almost every sample.

Boundary splits and stalls during SPILL come from a full ascending sweep of all 2048 input values and from a strided permutation of them. These mix codeword lengths from 1 to 13 bits, so every word-boundary offset occurs. Short hand-built sequences check carry-over of the accumulator across a flush, and that an empty flush emits nothing.

// File: rtl/ecg_cmp_pkg.sv
package ecg_cmp_pkg;

    localparam int CODE_W = 16;
    localparam int LEN_W  = 5;

    typedef struct packed {
        logic [CODE_W-1:0] bits;
        logic [LEN_W-1:0]  len;
    } cword_t;

    // Golomb order keeps every codeword within CODE_W bits
    function automatic int unsigned golomb_order(input int unsigned cw);
        return (cw > 6) ? cw - 5 : 0;
    endfunction

    // Zig-zag rank around mid-scale, then order-g exponential-Golomb
    function automatic cword_t code_of(input int unsigned sym, input int unsigned cw);
        cword_t      w;
        int unsigned mid;
        int unsigned r;
        int unsigned g;
        int unsigned v;
        int unsigned n;
        mid = 1 << (cw - 1);
        g   = golomb_order(cw);
        if (sym >= mid) r = 2 * (sym - mid);
        else            r = 2 * (mid - sym) - 1;
        v = r + (1 << g);
        n = 0;
        for (int i = 0; i < 24; i++) begin
            if ((v >> i) != 0) n = i;
        end
        w.bits = CODE_W'(v);
        w.len  = LEN_W'(2 * n - g + 1);
        return w;
    endfunction

endpackage

// File: rtl/ecg_requant.sv
module ecg_requant #(
    parameter int SAMPLE_W = 11,
    parameter int K        = 5,
    localparam int SYM_W   = SAMPLE_W - K,
    localparam int ACC_W   = K + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SYM_W-1:0]    sym
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             pulse;
    logic [SYM_W-1:0] coarse;

    always_comb begin
        coarse = sample[SAMPLE_W-1:K];
        sum    = acc_q + ACC_W'(sample[K-1:0]);
        pulse  = sum[K];
        sym    = (pulse && (coarse != '1)) ? coarse + 1'b1 : coarse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= {1'b0, sum[K-1:0]};
        end
    end

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc_q[K] == 1'b0);

    // R3
    sym_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (coarse == '1) |-> (sym == '1));

    // R9
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(acc_q));

endmodule

// File: rtl/ecg_code_rom.sv
module ecg_code_rom
    import ecg_cmp_pkg::*;
#(
    parameter int SYM_W = 6,
    localparam int NSYM = 1 << SYM_W
) (
    input  logic [SYM_W-1:0] sym,
    output cword_t           word
);

    cword_t table_q [NSYM];

    for (genvar i = 0; i < NSYM; i++) begin : g_entry
        assign table_q[i] = code_of(i, SYM_W);
    end

    assign word = table_q[sym];

endmodule

// File: rtl/ecg_packer.sv
module ecg_packer
    import ecg_cmp_pkg::*;
#(
    parameter int WORD_W  = 32,
    localparam int BUF_W  = WORD_W + CODE_W,
    localparam int FILL_W = $clog2(BUF_W + 1),
    localparam int NB_W   = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              flush,
    input  cword_t            cw,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [NB_W-1:0]   out_nbits
);

    typedef enum logic [1:0] {PK_FILL, PK_SPILL, PK_TAIL} pk_state_t;

    pk_state_t         state_q;
    pk_state_t         state_d;
    logic [BUF_W-1:0]  buf_q;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_sum;
    logic [BUF_W-1:0]  appended;
    logic              take;
    int                sh;

    always_comb begin
        in_ready = (state_q == PK_FILL) && !flush;
        take     = in_valid && in_ready;
        fill_sum = fill_q + FILL_W'(cw.len);
        sh       = BUF_W - int'(fill_q) - int'(cw.len);
        appended = buf_q | (BUF_W'(cw.bits) << sh);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_FILL: begin
                if (flush) begin
                    if (fill_q != '0) state_d = PK_TAIL;
                end else if (take && (fill_sum >= FILL_W'(WORD_W))) begin
                    state_d = PK_SPILL;
                end
            end
            PK_SPILL: state_d = PK_FILL;
            PK_TAIL:  state_d = PK_FILL;
            default:  state_d = PK_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PK_FILL;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q     <= '0;
            fill_q    <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
            out_nbits <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                PK_FILL: begin
                    if (take) begin
                        buf_q  <= appended;
                        fill_q <= fill_sum;
                    end
                end
                PK_SPILL: begin
                    out_word  <= buf_q[BUF_W-1 -: WORD_W];
                    out_nbits <= NB_W'(WORD_W);
                    out_valid <= 1'b1;
                    buf_q     <= buf_q << WORD_W;
                    fill_q    <= fill_q - FILL_W'(WORD_W);
                end
                PK_TAIL: begin
                    out_word  <= buf_q[BUF_W-1 -: WORD_W];
                    out_nbits <= NB_W'(fill_q);
                    out_valid <= 1'b1;
                    buf_q     <= '0;
                    fill_q    <= '0;
                end
                default: ;
            endcase
        end
    end

    // R5
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != PK_FILL) |-> !in_ready);

    // R6
    fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PK_FILL) |-> (fill_q < FILL_W'(WORD_W)));

    // R4
    code_fit_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> ((cw.len != '0) && (cw.len <= LEN_W'(CODE_W))
                  && ((BUF_W'(cw.bits) >> cw.len) == '0)));

    // R7
    tail_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_nbits < NB_W'(WORD_W))) |-> ((out_word << out_nbits) == '0));

    // R7
    clean_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PK_FILL) |-> ((buf_q << fill_q) == '0));

endmodule

// File: rtl/ecg_compressor.sv
module ecg_compressor
    import ecg_cmp_pkg::*;
#(
    parameter int SAMPLE_W = 11,
    parameter int K        = 5,
    parameter int WORD_W   = 32,
    localparam int SYM_W   = SAMPLE_W - K,
    localparam int NB_W    = $clog2(WORD_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                flush,
    output logic                in_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word,
    output logic [NB_W-1:0]     out_nbits
);

    if (K < 1 || K > 8) begin : g_bad_k
        $error("K must lie in 1..8");
    end

    logic             take;
    logic [SYM_W-1:0] sym;
    cword_t           cw;

    assign take = in_valid && in_ready;

    ecg_requant #(.SAMPLE_W(SAMPLE_W), .K(K)) u_requant (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .sample (in_sample),
        .sym    (sym)
    );

    ecg_code_rom #(.SYM_W(SYM_W)) u_rom (
        .sym  (sym),
        .word (cw)
    );

    ecg_packer #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .flush     (flush),
        .cw        (cw),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_nbits (out_nbits)
    );

endmodule

// File: tb/sim_ecg_compressor.sv
module sim_ecg_compressor;

    localparam int KB = 5;
    localparam int CB = 11 - KB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [10:0] in_sample = '0;
    logic        flush = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_word;
    logic [5:0]  out_nbits;

    int total = 0;
    int bad = 0;
    int words_seen = 0;
    int acc_m = 0;
    bit flushing = 1'b0;
    bit prev_valid = 1'b0;
    string tag = "R1";
    bit exp_q[$];

    always #10 clk = ~clk;

    ecg_compressor #(.SAMPLE_W(11), .K(KB), .WORD_W(32)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .flush(flush), .in_ready(in_ready), .out_valid(out_valid),
        .out_word(out_word), .out_nbits(out_nbits)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // model: requantize and encode one sample, queue its bits
    task automatic model_sample(input int s);
        int coarse;
        int frac;
        int sym;
        int mid;
        int r;
        int g;
        int v;
        int nb;
        int len;
        coarse = s / (1 << KB);
        frac   = s % (1 << KB);
        acc_m  = acc_m + frac;
        sym    = coarse;
        if (acc_m >= (1 << KB)) begin
            acc_m = acc_m - (1 << KB);
            if (coarse < (1 << CB) - 1) sym = coarse + 1;
        end
        mid = 1 << (CB - 1);
        r   = (sym >= mid) ? 2 * (sym - mid) : 2 * (mid - sym) - 1;
        g   = (CB > 6) ? CB - 5 : 0;
        v   = r + (1 << g);
        nb  = $clog2(v + 1);
        len = 2 * nb - 1 - g;
        for (int i = len - 1; i >= 0; i--) exp_q.push_back(((v >> i) & 1) != 0);
    endtask

    task automatic send(input int s);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 11'(s);
        while (!in_ready) @(negedge clk);
        model_sample(s);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_flush();
        repeat (3) @(negedge clk);
        flushing = 1'b1;
        flush = 1'b1;
        #1;
        check("R8", in_ready == 1'b0, in_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        repeat (4) @(negedge clk);
        flushing = 1'b0;
    endtask

    always @(negedge clk) begin : mon
        int n;
        logic [31:0] ew;
        if (!rst) begin
            if (prev_valid) check("R5", out_valid == 1'b0, out_valid, 0);
            prev_valid = out_valid;
            if (out_valid) begin
                words_seen++;
                n = flushing ? exp_q.size() : 32;
                if (n > exp_q.size()) n = exp_q.size();
                ew = '0;
                for (int i = 0; i < n; i++) ew[31 - i] = exp_q.pop_front();
                check(tag, out_nbits == 6'(n), out_nbits, n);
                check(tag, out_word == ew, out_word, ew);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1", in_ready == 1'b1, in_ready, 1);
        check("R1", out_valid == 1'b0, out_valid, 0);
        check("R1", out_nbits == 6'd0, out_nbits, 0);

        // R4 mid-scale symbol codes as a single 1; expect word F8000000, 5 bits
        tag = "R4";
        for (int i = 0; i < 5; i++) send(1024);
        do_flush();

        // R10 accumulator survives a flush: 1040 gives "1", then "011"
        tag = "R10";
        send(1040);
        do_flush();
        send(1040);
        do_flush();
        check("R10", exp_q.size() == 0, exp_q.size(), 0);

        // R7 flush with an empty packer emits nothing
        w0 = words_seen;
        do_flush();
        check("R7", words_seen == w0, words_seen, w0);

        // R2 full ascending sweep
        tag = "R2";
        for (int s = 0; s < 2048; s++) send(s);
        tag = "R7";
        do_flush();

        // R6 strided permutation exercises all boundary splits
        tag = "R6";
        for (int i = 0; i < 2048; i++) send((i * 37 + 5) % 2048);
        tag = "R7";
        do_flush();

        // R3 saturation at full scale
        tag = "R3";
        for (int i = 0; i < 40; i++) send(2047);
        do_flush();

        check("R5", words_seen > 100, words_seen, 100);
        check("R7", exp_q.size() == 0, exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule